// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives an abstract eight-channel analog-to-digital converter through conversion sequences and formats each 10-bit raw code into a 16-bit result register. Software-facing control is a single byte written with a strobe and read back at any time. The byte selects the result layout (left or right aligned), the number representation (unsigned or two's complement), whether sequences repeat, whether the channel steps from one conversion to the next, and the starting channel. The number of conversions per sequence comes from a separate 4-bit input.

Toward the converter the block issues a one-cycle start pulse together with a 3-bit channel code. It then waits for a one-cycle done pulse carrying the raw code. Only one conversion is in flight at any time, and a new start is never issued while the converter reports busy. Every write to the control byte abandons the running sequence and begins a fresh one with the new settings in the same clock edge. The done pulse of a conversion that was already in flight when the write came is thrown away.

Conversion k of a sequence lands in result register k. A one-cycle completion flag marks the end of every sequence, and in repeating mode it marks the end of every pass.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control byte reads back as written, except that bit 3 always reads 0 and ignores writes. Its fields are bit 7 for right alignment (1) or left alignment (0), bit 6 for signed (1) or unsigned (0), bit 5 for repeat, bit 4 for channel stepping, and bits 2:0 for the channel code.
- R2: After reset the control byte reads 0x00, all eight result registers read 0, and neither the start pulse nor the completion flag is asserted.
- R3: A control write abandons any sequence in progress and starts a new one from conversion 0 with the new settings. A done pulse for a conversion started before the write is not stored and does not count toward the new sequence.
- R4: With the repeat bit clear, exactly one sequence of conversions is performed and no further start pulse follows until the next control write.
- R5: With the repeat bit set, sequences run back to back, and the completion flag pulses once per pass.
- R6: With channel stepping clear, every conversion of the sequence uses the channel code.
- R7: With channel stepping set, conversion k uses the channel code plus k, modulo 8, so code 7 is followed by code 0.
- R8: The sequence length is the 4-bit length input, and the values 0 and 9 to 15 mean 8. Conversion k is written to result register k, and registers at or beyond the length keep their previous contents.
- R9: A left-aligned unsigned result holds the raw code in bits 15:6, with zeros in bits 5:0.
- R10: A right-aligned result holds the raw code in bits 9:0, with zeros in bits 15:10. It is unsigned whatever the signed bit says.
- R11: A left-aligned signed result holds the raw code with its bit 9 inverted, placed in bits 15:6, with zeros in bits 5:0.
- R12: A start pulse is issued only when no conversion is outstanding and the converter is not busy.
- R13: The completion flag is high for exactly one cycle. That cycle immediately follows the clock edge that stores the last result of a sequence, so the final result is already visible while the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read-back |
| seq_len | input | 4 | Conversions per sequence (0 means 8) |
| cnv_busy | input | 1 | Converter reports a conversion in progress |
| cnv_done | input | 1 | One-cycle pulse: raw code valid |
| cnv_code | input | 10 | Raw conversion code |
| cnv_start | output | 1 | One-cycle pulse: begin a conversion |
| cnv_chan | output | 3 | Channel for the conversion being started |
| results | output | 128 | Eight 16-bit result registers, register k in bits 16k+15:16k |
| seq_done | output | 1 | One-cycle sequence-complete flag |

## Verification
The hardest case to reach is a control write that lands while a conversion is still in flight. It must be followed by a late done pulse, and that pulse must be shown to be discarded and not stored. The bench converter model computes each code at start time from the channel and a changeable salt. The stimulus starts a stepping sequence, waits until the converter reports busy, changes the salt, and writes new settings. A stored stale result would shift every later register by one place and break the start count, so either check exposes it. The same path is also reached by aborting a repeating sequence in mid pass.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned CTL_W   = 8;
  localparam int unsigned CHSEL_W = 3;

  // Field positions inside the control byte
  localparam int unsigned POS_RJUST = 7;
  localparam int unsigned POS_SGN   = 6;
  localparam int unsigned POS_RPT   = 5;
  localparam int unsigned POS_STEP  = 4;

  typedef struct packed {
    logic               rjust;
    logic               sgn;
    logic               rpt;
    logic               step;
    logic [CHSEL_W-1:0] chan;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] b);
    ctl_t c;
    c.rjust = b[POS_RJUST];
    c.sgn   = b[POS_SGN];
    c.rpt   = b[POS_RPT];
    c.step  = b[POS_STEP];
    c.chan  = b[CHSEL_W-1:0];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
    logic [CTL_W-1:0] b;
    b                   = '0;
    b[POS_RJUST]        = c.rjust;
    b[POS_SGN]          = c.sgn;
    b[POS_RPT]          = c.rpt;
    b[POS_STEP]         = c.step;
    b[CHSEL_W-1:0]      = c.chan;
    return b;
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] rdata
);

  ctl_t ctl_q;
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) begin
      ctl_d = ctl_unpack(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl   = ctl_q;
  assign rdata = ctl_pack(ctl_q);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned LEN_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] restart_chan,
  input  logic             rpt,
  input  logic             step,
  input  logic [IDX_W-1:0] base_chan,
  input  logic [LEN_W-1:0] seq_len,
  input  logic             cnv_busy,
  input  logic             cnv_done,
  output logic             cnv_start,
  output logic [IDX_W-1:0] cnv_chan,
  output logic             store_en,
  output logic [IDX_W-1:0] store_idx,
  output logic             seq_done
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NUM_CH);

  logic             run_q,   run_d;
  logic [IDX_W-1:0] idx_q,   idx_d;
  logic [IDX_W-1:0] chan_q,  chan_d;
  logic             out_q,   out_d;
  logic             stale_q, stale_d;
  logic             done_q,  done_d;

  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] len_m1;
  logic [IDX_W-1:0] last_idx;
  logic             accept;
  logic             start;
  logic             at_last;

  always_comb begin
    if (seq_len == '0 || seq_len > FULL_LEN) begin
      len_eff = FULL_LEN;
    end else begin
      len_eff = seq_len;
    end
    len_m1   = len_eff - 1'b1;
    last_idx = len_m1[IDX_W-1:0];
    at_last  = (idx_q == last_idx);
    accept   = run_q & out_q & ~stale_q & cnv_done & ~restart;
    start    = run_q & ~out_q & ~cnv_busy & ~restart;
  end

  always_comb begin
    run_d   = run_q;
    idx_d   = idx_q;
    chan_d  = chan_q;
    out_d   = out_q;
    stale_d = stale_q;
    done_d  = 1'b0;

    if (cnv_done) begin
      out_d   = 1'b0;
      stale_d = 1'b0;
    end
    if (start) begin
      out_d = 1'b1;
    end

    if (accept) begin
      if (at_last) begin
        done_d = 1'b1;
        idx_d  = '0;
        chan_d = base_chan;
        run_d  = rpt;
      end else begin
        idx_d  = idx_q + 1'b1;
        chan_d = step ? chan_q + 1'b1 : chan_q;
      end
    end

    if (restart) begin
      run_d   = 1'b1;
      idx_d   = '0;
      chan_d  = restart_chan;
      stale_d = out_q & ~cnv_done;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      idx_q   <= '0;
      chan_q  <= '0;
      out_q   <= 1'b0;
      stale_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      idx_q   <= idx_d;
      chan_q  <= chan_d;
      out_q   <= out_d;
      stale_q <= stale_d;
      done_q  <= done_d;
    end
  end

  assign cnv_start = start;
  assign cnv_chan  = chan_q;
  assign store_en  = accept;
  assign store_idx = idx_q;
  assign seq_done  = done_q;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [CODE_W-1:0]       code,
  input  logic                    rjust,
  input  logic                    sgn,
  output logic [NUM_CH*RES_W-1:0] results
);

  localparam int unsigned PAD_W = RES_W - CODE_W;

  logic              sgn_eff;
  logic [CODE_W-1:0] sgn_code;
  logic [RES_W-1:0]  fmt;

  always_comb begin
    sgn_eff  = sgn & ~rjust;
    sgn_code = code ^ {sgn_eff, {(CODE_W-1){1'b0}}};
    if (rjust) begin
      fmt = {{PAD_W{1'b0}}, code};
    end else begin
      fmt = {sgn_code, {PAD_W{1'b0}}};
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    logic             hit;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] res_d;

    always_comb begin
      hit   = wr_en && (wr_idx == IDX_W'(i));
      res_d = hit ? fmt : res_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
      end else if (hit) begin
        res_q <= res_d;
      end
    end

    assign results[i*RES_W +: RES_W] = res_q;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned LEN_W  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ctl_we,
  input  logic [7:0]                          ctl_wdata,
  output logic [7:0]                          ctl_rdata,
  input  logic [LEN_W-1:0]                    seq_len,
  input  logic                                cnv_busy,
  input  logic                                cnv_done,
  input  logic [CODE_W-1:0]                   cnv_code,
  output logic                                cnv_start,
  output logic [CHSEL_W-1:0]                  cnv_chan,
  output logic [(2**CHSEL_W)*RES_W-1:0]       results,
  output logic                                seq_done
);

  localparam int unsigned NUM_CH = 2**CHSEL_W;

  logic               rst_sync_n;
  ctl_t               ctl;
  logic               store_en;
  logic [CHSEL_W-1:0] store_idx;

  adc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .ctl   (ctl),
    .rdata (ctl_rdata)
  );

  adc_seq_fsm #(
    .NUM_CH (NUM_CH),
    .IDX_W  (CHSEL_W),
    .LEN_W  (LEN_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .restart      (ctl_we),
    .restart_chan (ctl_wdata[CHSEL_W-1:0]),
    .rpt          (ctl.rpt),
    .step         (ctl.step),
    .base_chan    (ctl.chan),
    .seq_len      (seq_len),
    .cnv_busy     (cnv_busy),
    .cnv_done     (cnv_done),
    .cnv_start    (cnv_start),
    .cnv_chan     (cnv_chan),
    .store_en     (store_en),
    .store_idx    (store_idx),
    .seq_done     (seq_done)
  );

  adc_result_bank #(
    .NUM_CH (NUM_CH),
    .IDX_W  (CHSEL_W),
    .CODE_W (CODE_W),
    .RES_W  (RES_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (store_en),
    .wr_idx  (store_idx),
    .code    (cnv_code),
    .rjust   (ctl.rjust),
    .sgn     (ctl.sgn),
    .results (results)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       cnv_busy,
  input logic       cnv_done,
  input logic       cnv_start,
  input logic [2:0] cnv_chan,
  input logic       seq_done
);

  logic chk_out_q;
  logic chk_out_d;

  always_comb begin
    chk_out_d = chk_out_q;
    if (cnv_done) begin
      chk_out_d = 1'b0;
    end
    if (cnv_start) begin
      chk_out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_out_q <= 1'b0;
    end else begin
      chk_out_q <= chk_out_d;
    end
  end

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[3] == 1'b0);

  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == ($past(ctl_wdata) & 8'hF7));

  p_abort_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> !seq_done);

  p_single_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !ctl_rdata[5] && !ctl_we) |-> !cnv_start);

  p_fixed_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_start && !ctl_rdata[4]) |-> cnv_chan == ctl_rdata[2:0]);

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> (!chk_out_q && !cnv_busy));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .cnv_busy  (cnv_busy),
  .cnv_done  (cnv_done),
  .cnv_start (cnv_start),
  .cnv_chan  (cnv_chan),
  .seq_done  (seq_done)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

  logic         clk;
  logic         rst_n;
  logic         ctl_we;
  logic [7:0]   ctl_wdata;
  logic [7:0]   ctl_rdata;
  logic [3:0]   seq_len;
  logic         cnv_busy;
  logic         cnv_done;
  logic [9:0]   cnv_code;
  logic         cnv_start;
  logic [2:0]   cnv_chan;
  logic [127:0] results;
  logic         seq_done;

  int errors;
  int checks;
  int salt;
  int n_start;
  int n_done;
  int n_viol;
  int cyc;
  int lat;
  logic [9:0] pend;
  int exp_res [8];

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .seq_len   (seq_len),
    .cnv_busy  (cnv_busy),
    .cnv_done  (cnv_done),
    .cnv_code  (cnv_code),
    .cnv_start (cnv_start),
    .cnv_chan  (cnv_chan),
    .results   (results),
    .seq_done  (seq_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] code_of(input int ch, input int s);
    return 10'((ch * 131 + s * 37 + 5) % 1024);
  endfunction

  function automatic int fmt_of(input int code, input logic rj, input logic sg);
    if (rj) return code;
    if (sg) return ((code ^ 512) * 64);
    return code * 64;
  endfunction

  function automatic int res_at(input int k);
    return int'(results[k*16 +: 16]);
  endfunction

  // Converter model: busy for a few cycles after start, then one done pulse
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_busy <= 1'b0;
      cnv_done <= 1'b0;
      cnv_code <= '0;
      lat      <= 0;
      pend     <= '0;
    end else begin
      cnv_done <= 1'b0;
      if (cnv_start) begin
        cnv_busy <= 1'b1;
        lat      <= 2;
        pend     <= code_of(int'(cnv_chan), salt);
      end else if (cnv_busy) begin
        if (lat == 0) begin
          cnv_busy <= 1'b0;
          cnv_done <= 1'b1;
          cnv_code <= pend;
        end else begin
          lat <= lat - 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (cnv_start) n_start <= n_start + 1;
      if (seq_done)  n_done  <= n_done + 1;
      if (cnv_start && cnv_busy) n_viol <= n_viol + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R3 watchdog expired: actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] b);
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = b;
    @(negedge clk);
    ctl_we    = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int lim;
    lim = 0;
    while (n_done < target && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    if (n_done < target) chk("R4 sequence completion timeout", n_done, target);
  endtask

  // Run one single-pass sequence and check every register
  task automatic do_seq(input logic [7:0] cfg, input int len);
    int eff;
    int base_s;
    int base_d;
    int ch;
    int exp;
    string rq;
    eff = (len == 0 || len > 8) ? 8 : len;
    @(negedge clk);
    seq_len = 4'(len);
    base_s  = n_start;
    base_d  = n_done;
    write_ctl(cfg);
    chk("R1 read-back", int'(ctl_rdata), int'(cfg & 8'hF7));
    wait_done(base_d + 1);
    @(negedge clk);
    for (int k = 0; k < eff; k++) begin
      ch  = cfg[4] ? ((int'(cfg[2:0]) + k) % 8) : int'(cfg[2:0]);
      exp = fmt_of(int'(code_of(ch, salt)), cfg[7], cfg[6]);
      rq  = cfg[7] ? "R10" : (cfg[6] ? "R11" : "R9");
      rq  = {rq, cfg[4] ? " R7 R8" : " R6 R8"};
      chk(rq, res_at(k), exp);
      exp_res[k] = exp;
    end
    if (eff < 8) chk("R8 register beyond length untouched", res_at(eff), exp_res[eff]);
    repeat (10) @(negedge clk);
    chk("R4 R3 start count per sequence", n_start - base_s, eff);
    chk("R13 one completion pulse", n_done - base_d, 1);
  endtask

  initial begin
    int base_d;
    int base_s;
    errors    = 0;
    checks    = 0;
    salt      = 0;
    n_start   = 0;
    n_done    = 0;
    n_viol    = 0;
    cyc       = 0;
    rst_n     = 1'b0;
    ctl_we    = 1'b0;
    ctl_wdata = '0;
    seq_len   = 4'd1;
    for (int k = 0; k < 8; k++) exp_res[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R2 control reset", int'(ctl_rdata), 0);
    chk("R2 completion flag", int'(seq_done), 0);
    chk("R2 start idle", int'(cnv_start), 0);
    for (int k = 0; k < 8; k++) chk("R2 result reset", res_at(k), 0);
    repeat (5) @(negedge clk);
    chk("R2 no start without write", n_start, 0);

    // Reserved bit behaviour
    seq_len = 4'd2;
    write_ctl(8'hFF);
    chk("R1 reserved bit reads zero", int'(ctl_rdata), 8'hF7);
    write_ctl(8'h08);
    chk("R1 reserved bit ignores write", int'(ctl_rdata), 8'h00);
    base_d = n_done;
    wait_done(base_d + 1);
    repeat (10) @(negedge clk);

    // Sweep: formats, stepping, starting channel, lengths
    for (int f = 0; f < 8; f++) begin
      for (int ch = 0; ch < 8; ch++) begin
        for (int li = 0; li < 5; li++) begin
          int len;
          logic [7:0] cfg;
          len  = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : (li == 3) ? 8 : 11;
          cfg  = {f[2], f[1], 1'b0, f[0], 1'b0, 3'(ch)};
          salt = f * 64 + ch * 8 + li;
          do_seq(cfg, len);
        end
      end
    end

    // Repeating mode: several passes, one flag each
    salt    = 500;
    seq_len = 4'd3;
    @(negedge clk);
    base_d = n_done;
    base_s = n_start;
    write_ctl(8'h36);
    wait_done(base_d + 3);
    @(negedge clk);
    chk("R5 passes counted", n_done - base_d, 3);
    chk("R5 R7 wrap pass result 0", res_at(0), fmt_of(int'(code_of(6, salt)), 1'b0, 1'b0));
    chk("R5 R7 wrap pass result 1", res_at(1), fmt_of(int'(code_of(7, salt)), 1'b0, 1'b0));
    chk("R5 R7 wrap pass result 2", res_at(2), fmt_of(int'(code_of(0, salt)), 1'b0, 1'b0));
    chk("R5 starts continue", int'(n_start - base_s >= 9), 1);
    for (int k = 0; k < 3; k++) exp_res[k] = res_at(k);
    // Abort the repeating run mid-pass
    repeat (3) @(negedge clk);
    salt = 600;
    do_seq(8'h00, 3);

    // Abort with a conversion in flight: stale done must be dropped
    salt    = 700;
    seq_len = 4'd4;
    write_ctl(8'h12);
    while (!cnv_busy) @(negedge clk);
    salt = 800;
    do_seq(8'h15, 4);

    chk("R12 no start while converter busy", n_viol, 0);

    summary();
    $finish;
  end

endmodule